// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This block multiplies two W-bit integers over W clock cycles with one W-bit adder. It handles unsigned operands, and two's-complement operands when asked. A single 2W-bit product register does all the work. When an operation is accepted, its upper half is cleared and its lower half takes the multiplier. On every step the register's lowest bit decides whether the multiplicand is added into the upper half. The whole register then moves right by one place. The adder's carry-out becomes the new top bit, so no sum bit is lost.

For signed work, both operands are first turned into magnitudes and the product sign is remembered. On the last step, the register takes the two's complement of the final value when the operand signs differed. A caller raises `start` for one cycle while the block is idle. It waits for the one-cycle `done` pulse and then reads the product from `res_hi` and `res_lo`. The product stays there until another operation is accepted.

Top module: `seqmul`

## Requirements
- R1: After synchronous active-low reset, `busy` and `done` are 0 and `res_hi` and `res_lo` are all zeros.
- R2: A `start` seen high at a clock edge while `busy` is 0 is accepted. `busy` is then 1 for exactly W cycles, and `done` rises at the W-th edge after the accepting edge.
- R3: With `signed_mode` 0 at acceptance, {`res_hi`,`res_lo`} equals the unsigned product of `mcand` and `mplier`. For example, 1 times 7 gives 7.
- R4: With `signed_mode` 1 at acceptance, {`res_hi`,`res_lo`} equals the two's-complement product, including operands equal to the most negative value.
- R5: The carry out of each add is kept. With both unsigned operands all ones, `res_hi` is 2^W-2 and `res_lo` is 1.
- R6: A `start` while `busy` is 1 is ignored. It changes neither the product nor the cycle in which `done` appears.
- R7: `done` is high for one cycle only and is never high together with `busy`.
- R8: While `busy` is 0, `res_hi` and `res_lo` keep the last completed product (or zero after reset) until the next accepted start.
- R9: A zero operand gives an all-zero product in both modes. No negative zero appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a multiplication (used only while idle) |
| signed_mode | input | 1 | 1: operands are two's complement; 0: unsigned |
| mcand | input | W | Multiplicand operand |
| mplier | input | W | Multiplier operand |
| busy | output | 1 | High while the W steps run |
| done | output | 1 | One-cycle pulse when the product is ready |
| res_hi | output | W | Upper half of the 2W-bit product |
| res_lo | output | W | Lower half of the 2W-bit product |

## Verification
The hardest case to reach from the ports is a start request that arrives in the middle of a run, carrying operands and a mode that would give a different product. The bench raises such a request some cycles after a real acceptance. It then checks that the original product still arrives, and on the original cycle. A second hard case is the last step, where the carry and the conditional negation meet. Directed vectors cover it: all-ones unsigned operands, the most negative signed value on both inputs, and signed zero products. A stream of pseudo-random operands in both modes runs back to back, each start issued in the cycle `done` is seen.

// File: rtl/seqmul_pkg.sv
// Package: shared types for the sequential multiplier.
// Assumes nothing beyond IEEE 1800-2017 enums.
package seqmul_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_t;
endpackage

// File: rtl/seqmul_sign.sv
// Module: seqmul_sign
// Turns both operands into unsigned magnitudes and works out whether the
// product must be negated. In unsigned mode the operands pass through.
// Assumes W >= 2. The magnitude of the most negative value fits in W bits.
module seqmul_sign #(
    parameter int W = 32
) (
    input  logic         signed_mode,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         flip
);
    logic a_neg;
    logic b_neg;

    // Decide the operand signs and form the magnitudes.
    always_comb begin
        a_neg = signed_mode & op_a[W-1];
        b_neg = signed_mode & op_b[W-1];
        mag_a = a_neg ? (~op_a + {{(W-1){1'b0}}, 1'b1}) : op_a;
        mag_b = b_neg ? (~op_b + {{(W-1){1'b0}}, 1'b1}) : op_b;
        flip  = a_neg ^ b_neg;
    end
endmodule

// File: rtl/seqmul_step.sv
// Module: seqmul_step
// One shift-add step on the 2W-bit product register. If bit 0 is set, the
// multiplicand is added into the upper half with a (W+1)-bit sum. The sum,
// carry included, and the lower half then shift right by one place.
// Assumes the multiplier bits still to be used sit in the low end.
module seqmul_step #(
    parameter int W = 32,
    localparam int PW = 2 * W
) (
    input  logic [PW-1:0] prod_in,
    input  logic [W-1:0]  addend,
    output logic [PW-1:0] prod_out
);
    logic [W:0] sum;

    // Conditional half-width add, then a right shift that keeps the carry.
    always_comb begin
        sum      = {1'b0, prod_in[PW-1:W]} + (prod_in[0] ? {1'b0, addend} : {(W+1){1'b0}});
        prod_out = {sum, prod_in[W-1:1]};
    end
endmodule

// File: rtl/seqmul_ctrl.sv
// Module: seqmul_ctrl
// Sequencer for the multiplier. It accepts a start only when idle, runs
// exactly W steps and pulses done once after the last step.
// Assumes W >= 2. Reset is synchronous and active low.
module seqmul_ctrl
    import seqmul_pkg::*;
#(
    parameter int W = 32,
    localparam int CW = $clog2(W)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic last,
    output logic busy,
    output logic done
);
    mul_state_t    state;
    logic [CW-1:0] cnt;

    // Decode the phase signals from the state and the step count.
    always_comb begin
        load = (state == ST_IDLE) && start;
        step = (state == ST_RUN);
        last = step && (cnt == CW'(W - 1));
        busy = step;
    end

    // Advance the state, count the steps and register the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= last;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_RUN;
                        cnt   <= '0;
                    end
                end
                ST_RUN: begin
                    cnt <= cnt + CW'(1);
                    if (last) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/seqmul.sv
// Module: seqmul (top)
// Multi-cycle unsigned/signed multiplier built on one W-bit adder. The
// product register holds the multiplier in its low half and builds the
// partial product in its high half. The register is the result output, so
// the product stays visible until the next accepted start.
// Assumes W >= 2. Reset is synchronous and active low.
module seqmul #(
    parameter int W = 32,
    localparam int PW = 2 * W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         signed_mode,
    input  logic [W-1:0] mcand,
    input  logic [W-1:0] mplier,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] res_hi,
    output logic [W-1:0] res_lo
);
    logic          load;
    logic          step;
    logic          last;
    logic [W-1:0]  mag_a;
    logic [W-1:0]  mag_b;
    logic          flip;
    logic [W-1:0]  addend_q;
    logic          flip_q;
    logic [PW-1:0] prod_q;
    logic [PW-1:0] prod_nxt;

    seqmul_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .last  (last),
        .busy  (busy),
        .done  (done)
    );

    seqmul_sign #(.W(W)) u_sign (
        .signed_mode (signed_mode),
        .op_a        (mcand),
        .op_b        (mplier),
        .mag_a       (mag_a),
        .mag_b       (mag_b),
        .flip        (flip)
    );

    seqmul_step #(.W(W)) u_step (
        .prod_in  (prod_q),
        .addend   (addend_q),
        .prod_out (prod_nxt)
    );

    // Load the operands on acceptance. Step the product while running and
    // negate it on the final step when the operand signs differed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addend_q <= '0;
            flip_q   <= 1'b0;
            prod_q   <= '0;
        end else if (load) begin
            addend_q <= mag_a;
            flip_q   <= flip;
            prod_q   <= {{W{1'b0}}, mag_b};
        end else if (step) begin
            prod_q <= (last && flip_q) ? (~prod_nxt + {{(PW-1){1'b0}}, 1'b1}) : prod_nxt;
        end
    end

    // Split the product register into the two result words.
    always_comb begin
        res_hi = prod_q[PW-1:W];
        res_lo = prod_q[W-1:0];
    end
endmodule

// File: rtl/seqmul_chk.sv
// Module: seqmul_chk
// Property checker bound to seqmul. It observes ports only, captures the
// accepted operands and counts busy cycles to check the run length.
module seqmul_chk #(
    parameter int W = 32,
    localparam int PW = 2 * W,
    localparam int KW = $clog2(W + 1) + 1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         signed_mode,
    input logic [W-1:0] mcand,
    input logic [W-1:0] mplier,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] res_hi,
    input logic [W-1:0] res_lo
);
    logic [W-1:0]  ca;
    logic [W-1:0]  cb;
    logic          cs;
    logic [KW-1:0] runlen;
    logic [PW-1:0] wa;
    logic [PW-1:0] wb;
    logic [PW-1:0] want;

    // Capture the accepted operands and count the cycles of the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ca     <= '0;
            cb     <= '0;
            cs     <= 1'b0;
            runlen <= '0;
        end else if (start && !busy) begin
            ca     <= mcand;
            cb     <= mplier;
            cs     <= signed_mode;
            runlen <= '0;
        end else if (busy) begin
            runlen <= runlen + KW'(1);
        end
    end

    // Form the product the block should report.
    always_comb begin
        if (cs) begin
            wa   = {{W{ca[W-1]}}, ca};
            wb   = {{W{cb[W-1]}}, cb};
            want = $signed(wa) * $signed(wb);
        end else begin
            wa   = {{W{1'b0}}, ca};
            wb   = {{W{1'b0}}, cb};
            want = wa * wb;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> (!busy && !done && res_hi == '0 && res_lo == '0))
        else $error("R1: state not cleared by reset");
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy)
        else $error("R2: start not accepted");
    p_run_bound_r2: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (runlen < KW'(W)))
        else $error("R2: run longer than W cycles");
    p_run_len_r2: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (done && runlen == KW'(W)))
        else $error("R2: run length wrong");
    p_result_r3: assert property (@(posedge clk) disable iff (!rst_n) done |-> ({res_hi, res_lo} == want))
        else $error("R3/R4/R5: product wrong");
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done)
        else $error("R7: done longer than one cycle");
    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done))
        else $error("R7: busy and done together");
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable({res_hi, res_lo}))
        else $error("R8: result changed while idle");
endmodule

bind seqmul seqmul_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .signed_mode (signed_mode),
    .mcand       (mcand),
    .mplier      (mplier),
    .busy        (busy),
    .done        (done),
    .res_hi      (res_hi),
    .res_lo      (res_lo)
);

// File: tb/seqmul_tb.sv
module seqmul_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         signed_mode = 1'b0;
    logic [W-1:0] mcand = '0;
    logic [W-1:0] mplier = '0;
    logic         busy;
    logic         done;
    logic [W-1:0] res_hi;
    logic [W-1:0] res_lo;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;

    logic [2*W-1:0] exp_q[$];
    int             due_q[$];
    string          tag_q[$];
    logic [2*W-1:0] last_res = '0;
    bit             prev_done = 1'b0;
    logic [31:0]    lfsr = 32'h1234_5678;

    seqmul #(.W(W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .signed_mode (signed_mode),
        .mcand       (mcand),
        .mplier      (mplier),
        .busy        (busy),
        .done        (done),
        .res_hi      (res_hi),
        .res_lo      (res_lo)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [2*W-1:0] act, input logic [2*W-1:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y, input bit sm);
        logic [2*W-1:0] ex;
        logic [2*W-1:0] ey;
        if (sm) begin
            ex = {{W{x[W-1]}}, x};
            ey = {{W{y[W-1]}}, y};
            return $signed(ex) * $signed(ey);
        end
        ex = {{W{1'b0}}, x};
        ey = {{W{1'b0}}, y};
        return ex * ey;
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    // Driver: wait for idle, push the expected product and due cycle, pulse start.
    task automatic issue(input logic [W-1:0] x, input logic [W-1:0] y, input bit sm, input string tag);
        @(negedge clk);
        while (busy) @(negedge clk);
        exp_q.push_back(ref_mul(x, y, sm));
        due_q.push_back(cyc + 1 + W);
        tag_q.push_back(tag);
        mcand       = x;
        mplier      = y;
        signed_mode = sm;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // R6: a second request inside a run must not change product or timing.
    task automatic issue_with_intrusion(input logic [W-1:0] x, input logic [W-1:0] y, input bit sm);
        issue(x, y, sm, "R6");
        repeat (3) @(negedge clk);
        mcand       = ~x;
        mplier      = y + 32'd3;
        signed_mode = ~sm;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor: sample a quarter period after each edge and score the outputs.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (mon_on) begin
                if (busy && done) check(1'b0, "R7 busy with done", 2*W'(busy), 2*W'(0));
                if (done && prev_done) check(1'b0, "R7 done wider than one cycle", 2*W'(1), 2*W'(0));
                if (done) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R6 unexpected done", {res_hi, res_lo}, '0);
                    end else begin
                        logic [2*W-1:0] e;
                        int             d;
                        string          t;
                        e = exp_q.pop_front();
                        d = due_q.pop_front();
                        t = tag_q.pop_front();
                        check({res_hi, res_lo} == e, {t, " product"}, {res_hi, res_lo}, e);
                        check(cyc == d, {t, " R2 done cycle"}, 2*W'(cyc), 2*W'(d));
                    end
                    last_res = {res_hi, res_lo};
                end else if (!busy) begin
                    check({res_hi, res_lo} == last_res, "R8 idle hold", {res_hi, res_lo}, last_res);
                end
                prev_done = done;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #5;
        check(!busy && !done, "R1 flags after reset", 2*W'({busy, done}), '0);
        check({res_hi, res_lo} == '0, "R1 result after reset", {res_hi, res_lo}, '0);
        mon_on = 1'b1;

        issue(32'd1, 32'd7, 1'b0, "R3");
        issue(32'd12345, 32'd678, 1'b0, "R3");
        issue(32'h8000_0000, 32'd2, 1'b0, "R3");
        issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R5");
        issue(32'hFFFF_FFFF, 32'd1, 1'b0, "R5");
        issue(-32'sd7, 32'd2, 1'b1, "R4");
        issue(32'd7, -32'sd2, 1'b1, "R4");
        issue(-32'sd7, -32'sd2, 1'b1, "R4");
        issue(32'h8000_0000, 32'h8000_0000, 1'b1, "R4");
        issue(32'h8000_0000, 32'd1, 1'b1, "R4");
        issue(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R4");
        issue(32'd0, 32'hDEAD_BEEF, 1'b0, "R9");
        issue(32'd0, -32'sd5, 1'b1, "R9");
        issue(-32'sd9, 32'd0, 1'b1, "R9");
        issue_with_intrusion(32'd1000, 32'd3000, 1'b0);
        issue_with_intrusion(-32'sd1000, 32'd77, 1'b1);

        for (int i = 0; i < 60; i++) begin
            logic [W-1:0] x;
            logic [W-1:0] y;
            lfsr = next_rand(lfsr);
            x = lfsr;
            lfsr = next_rand(lfsr);
            y = lfsr;
            issue(x, y, i[0], (i[0] ? "R4" : "R3"));
        end

        // Let the last run finish, then observe a quiet stretch (R8).
        repeat (W + 10) @(negedge clk);
        check(exp_q.size() == 0, "R2 all results delivered", 2*W'(exp_q.size()), '0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule